// File: doc/BRIEF.md
# Shared-index memory dump read port

This block lets a register bus read out several small per-entry state memories through one common read pointer. Software first programs the pointer register with a starting index and a step. From then on, each read of any memory-backed register address returns the entry selected by the current index. The index then moves forward by the step, so a whole table can be dumped with back-to-back reads of one address. A step of 0 rereads the same entry. A step of 1 walks the table in order. Other steps stride through it.

The block drives a shared synchronous read address and one read enable per memory. The memory answers on the following cycle, and the block returns that word on the bus together with a one-cycle valid pulse. The read and write sides of the bus have separate addresses, so a pointer write and a memory read can land in the same cycle. The logic that fills the memories is outside this block.

Top module: `idx_csr_read`

## Requirements
- R1: After reset the read index and the step are both 0, `csr_rvalid` is 0, `csr_rdata` is 0 and no `mem_ren` bit is set.
- R2: A read of read address 0 (the pointer register) returns {zeros, step[7:0], index[7:0]} one cycle after the strobe, with `csr_rvalid` high. The index is in bits [7:0] and the step is in bits [15:8]. All higher bits read as 0.
- R3: A read of read address 4+k (k < NMEM) selects memory k. In the strobe cycle it sets only `mem_ren[k]` and drives `mem_raddr` with the current index. One cycle later `csr_rdata` carries memory k's returned word, with `csr_rvalid` high.
- R4: After every memory-backed read, to any of the memories, the index becomes (index + step) mod 256. The next read uses the new index.
- R5: A read of any address that is not memory-backed leaves the index unchanged. A read of an unmapped address (1 to 3, or at or above 4+NMEM) returns 0 with `csr_rvalid` high.
- R6: A write to write address 0 loads index = `csr_wdata[7:0]` and step = `csr_wdata[15:8]`. If a memory read happens in the same cycle, that read uses the old index, and the written value wins over the automatic advance.
- R7: An index of 16 or more selects entry (index mod 16). `mem_raddr` is the low 4 bits of the index.
- R8: Writes to any write address other than 0 have no effect on the index, on the step or on later read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_waddr | input | 4 | Register write address |
| csr_wdata | input | 16 | Register write data |
| csr_rd | input | 1 | Register read strobe |
| csr_raddr | input | 4 | Register read address |
| csr_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| csr_rdata | output | 64 | Read data |
| mem_ren | output | 3 | Per-memory read enable |
| mem_raddr | output | 4 | Shared memory entry address |
| mem_rdata | input | 192 | Memory read words, memory k at bits [64k+63:64k] |

## Verification
A wrong index shows up on the very next memory read. `mem_raddr` carries the bad value in the strobe cycle, and the wrong entry's word appears on `csr_rdata` one cycle later. A wrong step or a wrong wrap at 256 shows up after a single advance. The bench therefore reads across the wrap point, with a step of 0, with strides that alias modulo 16, and with a pointer write landing in the same cycle as a memory read. A bad step or index that is not used by a memory read still shows up at the next read of the pointer register.

// File: rtl/idx_csr_read.sv
module idx_csr_read #(
  parameter int NMEM     = 3,
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 4,
  parameter int IDX_W    = 8,
  parameter int DEPTH    = 16,
  parameter int MEM_BASE = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     csr_wr,
  input  logic [ADDR_W-1:0]        csr_waddr,
  input  logic [2*IDX_W-1:0]       csr_wdata,
  input  logic                     csr_rd,
  input  logic [ADDR_W-1:0]        csr_raddr,
  output logic                     csr_rvalid,
  output logic [DATA_W-1:0]        csr_rdata,
  output logic [NMEM-1:0]          mem_ren,
  output logic [$clog2(DEPTH)-1:0] mem_raddr,
  input  logic [NMEM*DATA_W-1:0]   mem_rdata
);
  localparam int EA_W = $clog2(DEPTH);

  logic [IDX_W-1:0]  idx_q, inc_q;
  logic              rv_q, mem_q;
  logic [ADDR_W-1:0] sel_q;
  logic [DATA_W-1:0] hold_q;
  logic              mem_hit, idx_rd, idx_wr;

  for (genvar k = 0; k < NMEM; k++) begin : g_ren
    assign mem_ren[k] = csr_rd && (csr_raddr == ADDR_W'(MEM_BASE + k));
  end

  assign mem_hit   = |mem_ren;
  assign idx_rd    = csr_rd && (csr_raddr == '0);
  assign idx_wr    = csr_wr && (csr_waddr == '0);
  assign mem_raddr = idx_q[EA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      inc_q  <= '0;
      rv_q   <= 1'b0;
      mem_q  <= 1'b0;
      sel_q  <= '0;
      hold_q <= '0;
    end else begin
      if (idx_wr) begin
        idx_q <= csr_wdata[IDX_W-1:0];
        inc_q <= csr_wdata[2*IDX_W-1:IDX_W];
      end else if (mem_hit) begin
        idx_q <= idx_q + inc_q;
      end
      rv_q   <= csr_rd;
      mem_q  <= mem_hit;
      sel_q  <= csr_raddr - ADDR_W'(MEM_BASE);
      hold_q <= idx_rd ? DATA_W'({inc_q, idx_q}) : '0;
    end
  end

  assign csr_rvalid = rv_q;
  assign csr_rdata  = !rv_q ? '0 :
                      mem_q ? mem_rdata[int'(sel_q)*DATA_W +: DATA_W] : hold_q;
endmodule

module idx_csr_read_chk #(
  parameter int NMEM     = 3,
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 4,
  parameter int IDX_W    = 8,
  parameter int MEM_BASE = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 csr_wr,
  input logic [ADDR_W-1:0]    csr_waddr,
  input logic [2*IDX_W-1:0]   csr_wdata,
  input logic                 csr_rd,
  input logic [ADDR_W-1:0]    csr_raddr,
  input logic                 csr_rvalid,
  input logic [DATA_W-1:0]    csr_rdata,
  input logic [NMEM-1:0]      mem_ren,
  input logic [IDX_W-1:0]     idx_q,
  input logic [IDX_W-1:0]     inc_q
);
  logic wr_idx, unmapped;
  assign wr_idx   = csr_wr && csr_waddr == '0;
  assign unmapped = csr_rd && csr_raddr != '0 &&
                    (int'(csr_raddr) < MEM_BASE || int'(csr_raddr) >= MEM_BASE + NMEM);

  assert_reset_quiet_R1: assert property (@(posedge clk) $rose(rst_n) |-> !csr_rvalid && csr_rdata == '0);
  assert_ren_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mem_ren) && (csr_rd || mem_ren == '0));
  assert_rvalid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n) csr_rd |=> csr_rvalid);
  assert_no_spurious_valid_R3: assert property (@(posedge clk) disable iff (!rst_n) !csr_rd |=> !csr_rvalid);
  assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ren != '0 && !wr_idx) |=> idx_q == IDX_W'($past(idx_q) + $past(inc_q)));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ren == '0 && !wr_idx) |=> $stable(idx_q) && $stable(inc_q));
  assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (!rst_n) unmapped |=> csr_rdata == '0);
  assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx |=> {inc_q, idx_q} == $past(csr_wdata));
endmodule

bind idx_csr_read idx_csr_read_chk #(
  .NMEM(NMEM), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .MEM_BASE(MEM_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_waddr(csr_waddr), .csr_wdata(csr_wdata),
  .csr_rd(csr_rd), .csr_raddr(csr_raddr), .csr_rvalid(csr_rvalid), .csr_rdata(csr_rdata),
  .mem_ren(mem_ren), .idx_q(idx_q), .inc_q(inc_q)
);

// File: tb/idx_csr_read_bench.sv
module idx_csr_read_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         csr_wr = 1'b0, csr_rd = 1'b0;
  logic [3:0]   csr_waddr = '0, csr_raddr = '0;
  logic [15:0]  csr_wdata = '0;
  logic         csr_rvalid;
  logic [63:0]  csr_rdata;
  logic [2:0]   mem_ren;
  logic [3:0]   mem_raddr;
  logic [191:0] mem_rdata = '0;

  int vectors = 0, errors = 0;
  int m_idx = 0, m_inc = 0;
  logic        e_rv = 1'b0;
  logic [63:0] e_rd = '0;

  always #4 clk = ~clk;

  idx_csr_read u_idx_csr_read (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_waddr(csr_waddr), .csr_wdata(csr_wdata),
    .csr_rd(csr_rd), .csr_raddr(csr_raddr), .csr_rvalid(csr_rvalid), .csr_rdata(csr_rdata),
    .mem_ren(mem_ren), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
  );

  function automatic logic [63:0] content(int k, int e);
    return {8'(k + 1), 24'h5a5a5a, 16'(e * 37 + k * 11), 16'(e ^ 16'hc3c3)};
  endfunction

  always @(posedge clk)
    for (int k = 0; k < 3; k++)
      if (mem_ren[k]) mem_rdata[k*64 +: 64] <= content(k, int'(mem_raddr));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic rd, input int ra, input logic wr, input int wa, input int wd,
                     input string req);
    logic [2:0] e_ren;
    @(negedge clk);
    csr_rd = rd; csr_raddr = 4'(ra); csr_wr = wr; csr_waddr = 4'(wa); csr_wdata = 16'(wd);
    #1;
    chk({req, " rvalid"}, 64'(csr_rvalid), 64'(e_rv));
    chk({req, " rdata"}, csr_rdata, e_rd);
    e_ren = '0;
    if (rd && ra >= 4 && ra < 7) e_ren[ra-4] = 1'b1;
    chk({req, " R3 ren"}, 64'(mem_ren), 64'(e_ren));
    if (e_ren != '0) chk({req, " R7 raddr"}, 64'(mem_raddr), 64'(m_idx % 16));
    e_rv = rd;
    if (!rd) e_rd = '0;
    else if (ra == 0) e_rd = 64'((m_inc << 8) | m_idx);
    else if (ra >= 4 && ra < 7) e_rd = content(ra - 4, m_idx % 16);
    else e_rd = '0;
    if (wr && wa == 0) begin
      m_idx = wd & 255; m_inc = (wd >> 8) & 255;
    end else if (e_ren != '0) m_idx = (m_idx + m_inc) % 256;
  endtask

  task automatic rd(input int ra, input string req); cyc(1, ra, 0, 0, 0, req); endtask
  task automatic wr(input int wa, input int wd, input string req); cyc(0, 0, 1, wa, wd, req); endtask

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        rd(0, "R1 R2 reset index");
        wr(0, 16'h0100, "R6 program 0/1");
        rd(0, "R2 pointer readback");
        for (int i = 0; i < 18; i++) rd(4, "R3 R4 R7 walk mem0");
        for (int i = 0; i < 6; i++) rd(4 + i % 3, "R4 shared index across memories");
        rd(0, "R5 pointer read no advance");
        rd(1, "R5 unmapped 1");
        rd(7, "R5 unmapped 7");
        rd(15, "R5 unmapped 15");
        rd(5, "R5 index unchanged after unmapped");
        wr(0, 16'h03fa, "R6 program 250/3");
        for (int i = 0; i < 5; i++) rd(6, "R4 wrap at 256");
        wr(0, 16'h0007, "R6 step zero");
        for (int i = 0; i < 3; i++) rd(5, "R4 step zero repeats");
        wr(3, 16'hffff, "R8 write other address");
        wr(9, 16'h1234, "R8 write other address");
        rd(0, "R8 pointer untouched");
        wr(0, 16'h1109, "R6 program 9/17");
        cyc(1, 4, 1, 0, 16'h0520, "R6 write beats advance");
        for (int i = 0; i < 4; i++) rd(4 + i % 3, "R6 R7 after simultaneous write");
        cyc(1, 0, 1, 0, 16'h0202, "R6 pointer read with write");
        rd(0, "R6 written value visible");
        cyc(0, 0, 0, 0, 0, "flush");
        cyc(0, 0, 0, 0, 0, "flush");
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule